// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This unit governs the low-power state of a small microcontroller core. When the core issues a sleep strobe, the controller checks whether any interrupt source already has both its flag and its enable set. If one does, the request is dropped and nothing changes. Otherwise the controller gates off the oscillator, pulses a clear to the free-running watchdog, and updates two status bits: a power-down bit, which reads 0 after a completed sleep, and a time-out bit, which reads 0 after a watchdog wake.

While the core is asleep, only a few events can end the state. The first is an enabled interrupt from a source that can signal without a clock; a parameter mask marks those sources. The second is a watchdog time-out, and only when the watchdog is enabled. The third is the external reset input. An external reset restarts the core. Every other wake continues the program. On a wake the unit restores the oscillator and raises a one-cycle wake pulse. With that pulse it also gives the core one of two directions: continue in line at the already prefetched next instruction, or run that instruction and then vector to the interrupt address. The global interrupt enable picks between the two but has no say in whether the wake happens.

A clear-watchdog strobe from the core also clears the watchdog and sets both status bits. This gives a known state before the core sleeps.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset (por_n low), pd_bit=1, to_bit=1, osc_en=1, asleep=0, and wdt_clr, wake_pulse, resume_next, take_vector and core_rst are all 0.
- R2: A sleep_req while awake, with no source i having irq_flag[i] and irq_en[i] both 1, gives the following on the next cycle: asleep=1, osc_en=0, pd_bit=0, to_bit=1, and wdt_clr high for exactly that one cycle.
- R3: A sleep_req while awake, when any source (masked or not) has its flag and its enable both 1, has no effect: asleep stays 0, osc_en stays 1, wdt_clr stays 0, and pd_bit and to_bit keep their values.
- R4: While asleep, a source i with irq_flag[i]=1, irq_en[i]=1 and bit i of ASYNC_MASK set ends the sleep on the next cycle: wake_pulse=1 for one cycle, osc_en=1 and asleep=0, whatever the value of gie. A flag from a source whose enable or mask bit is 0 leaves the unit asleep.
- R5: Every wake_pulse comes with exactly one of resume_next and take_vector. take_vector=1 only when an interrupt caused the wake and gie=1. Neither output is ever high without wake_pulse.
- R6: While asleep, wdt_timeout with wdt_en=1 wakes the unit and clears to_bit, and pd_bit stays 0. With wdt_en=0 the time-out is ignored. A time-out while awake leaves to_bit unchanged.
- R7: ext_rst_n low, sampled on a clock edge, gives core_rst=1, asleep=0 and osc_en=1 on the next cycle. wake_pulse stays 0, and pd_bit and to_bit keep their values.
- R8: clrwdt_req while awake, without sleep_req, pulses wdt_clr for one cycle and sets pd_bit=1 and to_bit=1. While asleep, clrwdt_req is ignored. When sleep_req is high in the same cycle, the sleep request takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (free-running in this model) |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, sampled |
| sleep_req | input | 1 | One-cycle strobe from the core executing a sleep |
| clrwdt_req | input | 1 | One-cycle strobe from the core executing a watchdog clear |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| irq_flag | input | NUM_SRC | Per-source interrupt flags |
| irq_en | input | NUM_SRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_en | output | 1 | Oscillator clock-gate enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| pd_bit | output | 1 | Power-down status (0 after a completed sleep) |
| to_bit | output | 1 | Time-out status (0 after a watchdog wake) |
| asleep | output | 1 | Unit is in the power-down state |
| wake_pulse | output | 1 | One-cycle wake indication |
| resume_next | output | 1 | Continue in line after the sleep (with wake_pulse) |
| take_vector | output | 1 | Run the next instruction, then vector to the interrupt address (with wake_pulse) |
| core_rst | output | 1 | Core reset request from the external reset pin |

## Verification
The bench sweeps every enable pattern against every nonzero flag pattern, with both settings of the global enable. A design that tested only the masked sources for the pending check would enter sleep instead of treating it as a no-op. A design that applied the mask to the wrong bits would wake on a source that cannot signal without a clock, or stay asleep on one that can. An interrupt arriving only after the sleep has completed is checked separately. That case catches a unit that fails to wake when the interrupt comes during the sleep, or that lets the global enable block the wake. The bench also covers an external reset during sleep, a clear-watchdog strobe while asleep or together with a sleep strobe, and a watchdog time-out with the watchdog disabled. A wrong implementation would corrupt pd_bit or to_bit, or raise a wake pulse on a reset.

// File: rtl/swc_pkg.sv
package swc_pkg;

    // Registered control outputs of the sleep sequencer
    typedef struct packed {
        logic asleep;
        logic osc_en;
        logic wdt_clr;
        logic wake;
        logic resume;
        logic vector;
        logic core_rst;
    } swc_ctl_t;

    // Power-down and time-out status bits
    typedef struct packed {
        logic pd;
        logic to;
    } swc_stat_t;

    localparam swc_ctl_t CTL_RESET = '{
        asleep:   1'b0,
        osc_en:   1'b1,
        wdt_clr:  1'b0,
        wake:     1'b0,
        resume:   1'b0,
        vector:   1'b0,
        core_rst: 1'b0
    };

    localparam swc_stat_t STAT_RESET = '{pd: 1'b1, to: 1'b1};

endpackage

// File: rtl/swc_src_eval.sv
// Per-source interrupt evaluation: any enabled pending source, and the
// subset that is able to raise a wake without a running clock.
module swc_src_eval #(
    parameter int               NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0] ASYNC_MASK = 4'b1011
) (
    input  logic [NUM_SRC-1:0] irq_flag,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               any_pending,
    output logic               any_wake
);
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] wake_hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = irq_flag[i] & irq_en[i];
        if (ASYNC_MASK[i]) begin : g_async
            assign wake_hit[i] = hit[i];
        end else begin : g_sync
            assign wake_hit[i] = 1'b0;
        end
    end

    assign any_pending = |hit;
    assign any_wake    = |wake_hit;
endmodule

// File: rtl/swc_status_bits.sv
// Holds the power-down and time-out status bits.
module swc_status_bits
    import swc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sleep_enter,
    input  logic wdt_wake,
    input  logic clr_cmd,
    output logic pd_bit,
    output logic to_bit
);
    swc_stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (sleep_enter) begin
            stat_d.pd = 1'b0;
            stat_d.to = 1'b1;
        end else if (wdt_wake) begin
            stat_d.to = 1'b0;
        end else if (clr_cmd) begin
            stat_d.pd = 1'b1;
            stat_d.to = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stat_q <= STAT_RESET;
        else        stat_q <= stat_d;
    end

    assign pd_bit = stat_q.pd;
    assign to_bit = stat_q.to;

    // Watchdog wake leaves time-out low and power-down untouched (R6)
    p_wdt_wake_to_r6: assert property (@(posedge clk) disable iff (!por_n)
        wdt_wake |=> (!stat_q.to && (stat_q.pd == $past(stat_q.pd))));

    // Clear command sets both status bits (R8)
    p_clr_sets_bits_r8: assert property (@(posedge clk) disable iff (!por_n)
        (clr_cmd && !sleep_enter && !wdt_wake) |=> (stat_q.pd && stat_q.to));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int                 NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0] ASYNC_MASK = 4'b1011
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_n,
    input  logic               sleep_req,
    input  logic               clrwdt_req,
    input  logic               wdt_en,
    input  logic               wdt_timeout,
    input  logic [NUM_SRC-1:0] irq_flag,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               gie,
    output logic               osc_en,
    output logic               wdt_clr,
    output logic               pd_bit,
    output logic               to_bit,
    output logic               asleep,
    output logic               wake_pulse,
    output logic               resume_next,
    output logic               take_vector,
    output logic               core_rst
);
    swc_ctl_t ctl_d, ctl_q;

    logic any_pending;
    logic any_wake;
    logic ext_rst;
    logic accept_sleep;
    logic clr_cmd;
    logic wdt_wake;
    logic irq_wake;

    swc_src_eval #(
        .NUM_SRC    (NUM_SRC),
        .ASYNC_MASK (ASYNC_MASK)
    ) u_src_eval (
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .any_pending (any_pending),
        .any_wake    (any_wake)
    );

    // Event decode
    always_comb begin
        ext_rst      = !ext_rst_n;
        accept_sleep = !ctl_q.asleep && sleep_req && !any_pending && !ext_rst;
        clr_cmd      = !ctl_q.asleep && clrwdt_req && !sleep_req && !ext_rst;
        wdt_wake     = ctl_q.asleep && wdt_en && wdt_timeout && !ext_rst;
        irq_wake     = ctl_q.asleep && any_wake && !ext_rst;
    end

    // Next-state computation
    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.wdt_clr  = 1'b0;
        ctl_d.wake     = 1'b0;
        ctl_d.resume   = 1'b0;
        ctl_d.vector   = 1'b0;
        ctl_d.core_rst = 1'b0;
        if (ext_rst) begin
            ctl_d.asleep   = 1'b0;
            ctl_d.osc_en   = 1'b1;
            ctl_d.core_rst = 1'b1;
        end else if (accept_sleep) begin
            ctl_d.asleep  = 1'b1;
            ctl_d.osc_en  = 1'b0;
            ctl_d.wdt_clr = 1'b1;
        end else if (clr_cmd) begin
            ctl_d.wdt_clr = 1'b1;
        end else if (wdt_wake || irq_wake) begin
            ctl_d.asleep = 1'b0;
            ctl_d.osc_en = 1'b1;
            ctl_d.wake   = 1'b1;
            ctl_d.vector = irq_wake && gie;
            ctl_d.resume = !(irq_wake && gie);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    swc_status_bits u_status (
        .clk         (clk),
        .por_n       (por_n),
        .sleep_enter (accept_sleep),
        .wdt_wake    (wdt_wake),
        .clr_cmd     (clr_cmd),
        .pd_bit      (pd_bit),
        .to_bit      (to_bit)
    );

    assign osc_en      = ctl_q.osc_en;
    assign wdt_clr     = ctl_q.wdt_clr;
    assign asleep      = ctl_q.asleep;
    assign wake_pulse  = ctl_q.wake;
    assign resume_next = ctl_q.resume;
    assign take_vector = ctl_q.vector;
    assign core_rst    = ctl_q.core_rst;

    // Oscillator is off exactly while asleep (R2, R4)
    p_osc_off_asleep_r2: assert property (@(posedge clk) disable iff (!por_n)
        asleep != osc_en);

    // Entering sleep comes with a watchdog clear and cleared power-down (R2)
    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(asleep) |-> (wdt_clr && !pd_bit && to_bit));

    // Pending enabled interrupt turns sleep into a no-op (R3)
    p_sleep_noop_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!asleep && sleep_req && any_pending && ext_rst_n) |=> (!asleep && !wdt_clr));

    // Masked enabled interrupt wakes regardless of gie (R4)
    p_irq_wakes_r4: assert property (@(posedge clk) disable iff (!por_n)
        (asleep && any_wake && ext_rst_n) |=> (wake_pulse && !asleep));

    // Exactly one resume direction per wake, none otherwise (R5)
    p_direction_r5: assert property (@(posedge clk) disable iff (!por_n)
        (resume_next || take_vector || wake_pulse) |-> $countones({resume_next, take_vector, wake_pulse}) == 2);

    // External reset restarts the core without a wake pulse (R7)
    p_ext_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n |=> (core_rst && !asleep && !wake_pulse));
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
    localparam int         NSRC = 4;
    localparam logic [3:0] MASK = 4'b1011;

    logic clk = 1'b0;
    logic por_n, ext_rst_n, sleep_req, clrwdt_req, wdt_en, wdt_timeout, gie;
    logic [NSRC-1:0] irq_flag, irq_en;
    logic osc_en, wdt_clr, pd_bit, to_bit, asleep, wake_pulse;
    logic resume_next, take_vector, core_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sleep_wake_ctrl #(.NUM_SRC(NSRC), .ASYNC_MASK(MASK)) u_sleep_wake_ctrl (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sleep_req(sleep_req),
        .clrwdt_req(clrwdt_req), .wdt_en(wdt_en), .wdt_timeout(wdt_timeout),
        .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .osc_en(osc_en),
        .wdt_clr(wdt_clr), .pd_bit(pd_bit), .to_bit(to_bit), .asleep(asleep),
        .wake_pulse(wake_pulse), .resume_next(resume_next),
        .take_vector(take_vector), .core_rst(core_rst)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drop strobes at the falling edge, let the caller set inputs, then wait
    // one rising edge and sample just after it.
    task automatic clear_strobes();
        @(negedge clk);
        sleep_req = 0; clrwdt_req = 0; wdt_timeout = 0; ext_rst_n = 1;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic do_sleep();
        clear_strobes(); irq_flag = '0; sleep_req = 1; settle();
        check("R2", "asleep", asleep, 1);
        check("R2", "osc_en", osc_en, 0);
        check("R2", "pd", pd_bit, 0);
        check("R2", "to", to_bit, 1);
        check("R2", "wdt_clr", wdt_clr, 1);
    endtask

    task automatic wdt_wake();
        clear_strobes(); wdt_en = 1; wdt_timeout = 1; settle();
        check("R6", "wake", wake_pulse, 1);
        check("R6", "to", to_bit, 0);
        check("R6", "pd", pd_bit, 0);
        check("R5", "vector", take_vector, 0);
        check("R5", "resume", resume_next, 1);
    endtask

    initial begin
        por_n = 0; ext_rst_n = 1; sleep_req = 0; clrwdt_req = 0;
        wdt_en = 0; wdt_timeout = 0; gie = 0; irq_flag = '0; irq_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) por_n = 1;
        settle();
        check("R1", "pd", pd_bit, 1);
        check("R1", "to", to_bit, 1);
        check("R1", "osc_en", osc_en, 1);
        check("R1", "asleep", asleep, 0);
        check("R1", "pulses", {wdt_clr, wake_pulse, resume_next, take_vector, core_rst}, 0);

        // Watchdog time-out while awake does not touch to_bit (R6)
        clear_strobes(); wdt_en = 1; wdt_timeout = 1; settle();
        check("R6", "awake to", to_bit, 1);
        check("R6", "awake wake", wake_pulse, 0);

        // Sweep enables, flags and gie
        for (int e = 0; e < 16; e++) begin
            for (int f = 1; f < 16; f++) begin
                for (int g = 0; g < 2; g++) begin
                    logic pend, wk;
                    pend = ((e & f) != 0);
                    wk   = ((e & f & MASK) != 0);
                    gie = g[0]; irq_en = e[3:0];

                    clear_strobes(); irq_flag = '0; clrwdt_req = 1; settle();
                    check("R8", "wdt_clr", wdt_clr, 1);
                    check("R8", "pd", pd_bit, 1);
                    check("R8", "to", to_bit, 1);

                    clear_strobes(); irq_flag = f[3:0]; sleep_req = 1; settle();
                    if (pend) begin
                        check("R3", "asleep", asleep, 0);
                        check("R3", "wdt_clr", wdt_clr, 0);
                        check("R3", "pd/to", {pd_bit, to_bit}, 2'b11);
                        do_sleep();
                        clear_strobes(); irq_flag = f[3:0]; settle();
                        check("R4", "wake", wake_pulse, wk);
                        check("R4", "asleep", asleep, !wk);
                        if (wk) begin
                            check("R5", "vector", take_vector, g[0]);
                            check("R5", "resume", resume_next, !g[0]);
                            check("R4", "osc_en", osc_en, 1);
                            clear_strobes(); settle();
                            check("R4", "wake one cycle", wake_pulse, 0);
                            check("R5", "direction cleared", {resume_next, take_vector}, 0);
                        end else begin
                            clear_strobes(); wdt_en = 0; wdt_timeout = 1; settle();
                            check("R6", "disabled wdt", asleep, 1);
                            wdt_wake();
                        end
                    end else begin
                        check("R2", "asleep", asleep, 1);
                        check("R2", "pd", pd_bit, 0);
                        check("R2", "wdt_clr", wdt_clr, 1);
                        wdt_wake();
                    end
                end
            end
        end

        // External reset during sleep (R7)
        irq_en = '0; gie = 0;
        do_sleep();
        clear_strobes(); ext_rst_n = 0; settle();
        check("R7", "core_rst", core_rst, 1);
        check("R7", "asleep", asleep, 0);
        check("R7", "osc_en", osc_en, 1);
        check("R7", "wake", wake_pulse, 0);
        check("R7", "pd/to", {pd_bit, to_bit}, 2'b01);
        clear_strobes(); settle();
        check("R7", "core_rst released", core_rst, 0);

        // Clear-watchdog while asleep is ignored (R8)
        do_sleep();
        clear_strobes(); clrwdt_req = 1; settle();
        check("R8", "asleep clr", wdt_clr, 0);
        check("R8", "asleep pd", pd_bit, 0);
        wdt_wake();

        // Sleep and clear-watchdog together: sleep wins (R8)
        clear_strobes(); sleep_req = 1; clrwdt_req = 1; settle();
        check("R8", "both asleep", asleep, 1);
        check("R8", "both pd", pd_bit, 0);
        wdt_wake();

        clear_strobes(); settle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule